// File: doc/BRIEF.md
# Masked Polarity-Selectable Fault Monitor

This block watches a bank of fault and condition inputs (supply fault flags, general logic inputs, warning flags) while a power sequencer sits in a monitoring state. It raises one fault flag when any enabled input is at the level chosen as the fault level. Each input has its own mask bit, which takes it out of the combine, and its own sense bit, which picks whether high or low counts as a fault. The flag goes straight to the sequencer's next-state logic.

No delay or glitch filter sits in the path. After one register stage, the flag follows the inputs. When the sequencer enters a new state, it pulses `cfg_load` with that state's mask and sense words. The block holds the words in a shadow copy and counts out a fixed reload time, which models the configuration download. During that time it shows `busy` and holds the flag low. At the end of the reload it applies both words together.

Top module: `fault_mon`

## Requirements
- R1: `fault` is a register. One cycle after the inputs are sampled, it is high when at least one input is both enabled and at its fault level. Outside reload, it is low otherwise.
- R2: When mask bit i is 1, input i has no effect on `fault`. With every bit masked, `fault` stays low whatever the inputs do.
- R3: When sense bit i is 1, a high level on input i is a fault. When sense bit i is 0, a low level on input i is a fault.
- R4: There is no filtering. A fault level on an input that lasts one cycle gives a `fault` pulse of exactly one cycle, one cycle later.
- R5: `busy` rises in the cycle after `cfg_load` is sampled high. It then stays high for exactly RELOAD_CYC cycles.
- R6: `fault` is low in the cycle after `cfg_load` and in every cycle in which `busy` was high at the preceding edge.
- R7: The mask and sense words are captured only at `cfg_load`. Both take effect together at the edge where `busy` falls. Changes on `cfg_mask`/`cfg_sense` with no `cfg_load` are ignored.
- R8: A `cfg_load` during a reload captures the new words and restarts the reload count from the beginning.
- R9: Reset is synchronous and active high. It clears `busy` and `fault`, masks every input and clears every sense bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_in | input | N_IN | Monitored fault/condition inputs |
| cfg_load | input | 1 | Pulse that starts a configuration reload |
| cfg_mask | input | N_IN | New mask word (1 = input ignored), captured at `cfg_load` |
| cfg_sense | input | N_IN | New sense word (1 = high is fault), captured at `cfg_load` |
| fault | output | 1 | Registered combined fault flag |
| busy | output | 1 | Configuration reload in progress |

## Verification
The assertions check on every cycle:
- the blanking of `fault` after a load pulse and during `busy`;
- that `busy` persists until the reload counter runs out and drops when it does;
- the restart of the count on a new load;
- that the applied mask and sense words never change outside the completion edge;
- the silence of a fully masked bank;
- the reset state.

Only the bench's scenarios can show:
- the exact value of the flag for particular mask, sense and input patterns;
- the one-cycle response to a single-cycle input pulse;
- that words captured at load, and not later bus values, are the ones that take effect;
- the total length of `busy` counted from the outside.

// File: rtl/fmon_pkg.sv
package fmon_pkg;

    localparam int unsigned DEF_N_IN       = 8;
    localparam int unsigned DEF_RELOAD_CYC = 1000;

    typedef enum logic {
        RL_IDLE = 1'b0,
        RL_BUSY = 1'b1
    } rl_state_e;

    // One input is at fault when it is enabled and sits at its fault level
    function automatic logic bit_hit(input logic lvl, input logic msk, input logic sns);
        return !msk && (lvl == sns);
    endfunction

endpackage

// File: rtl/fmon_reload.sv
module fmon_reload
    import fmon_pkg::*;
#(
    parameter int unsigned N_IN       = DEF_N_IN,
    parameter int unsigned RELOAD_CYC = DEF_RELOAD_CYC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_load,
    input  logic [N_IN-1:0] cfg_mask,
    input  logic [N_IN-1:0] cfg_sense,
    output logic [N_IN-1:0] act_mask,
    output logic [N_IN-1:0] act_sense,
    output logic            busy
);

    localparam int unsigned CW = (RELOAD_CYC > 1) ? $clog2(RELOAD_CYC) : 1;
    localparam logic [CW-1:0] CNT_START = CW'(RELOAD_CYC - 1);

    rl_state_e       state_q;
    logic [CW-1:0]   cnt_q;
    logic [N_IN-1:0] shd_mask_q, shd_sense_q;
    logic [N_IN-1:0] act_mask_q, act_sense_q;
    logic            last_w;

    assign last_w = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= RL_IDLE;
            cnt_q       <= '0;
            shd_mask_q  <= '1;
            shd_sense_q <= '0;
            act_mask_q  <= '1;
            act_sense_q <= '0;
        end else if (cfg_load) begin
            state_q     <= RL_BUSY;
            cnt_q       <= CNT_START;
            shd_mask_q  <= cfg_mask;
            shd_sense_q <= cfg_sense;
        end else if (state_q == RL_BUSY) begin
            if (last_w) begin
                state_q     <= RL_IDLE;
                act_mask_q  <= shd_mask_q;
                act_sense_q <= shd_sense_q;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy      = (state_q == RL_BUSY);
    assign act_mask  = act_mask_q;
    assign act_sense = act_sense_q;

    // R5: reload keeps going until the counter is spent
    a_r5_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !last_w && !cfg_load) |=> busy);

    // R5: reload ends when the counter is spent
    a_r5_busy_ends: assert property (@(posedge clk) disable iff (rst)
        (busy && last_w && !cfg_load) |=> !busy);

    // R8: any load pulse (re)starts a full count
    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (busy && cnt_q == CNT_START));

    // R7: applied words change only at the completion edge
    a_r7_atomic: assert property (@(posedge clk) disable iff (rst)
        !(busy && last_w && !cfg_load) |=> ($stable(act_mask_q) && $stable(act_sense_q)));

endmodule

// File: rtl/fmon_bit_det.sv
module fmon_bit_det
    import fmon_pkg::*;
(
    input  logic lvl,
    input  logic msk,
    input  logic sns,
    output logic hit
);

    assign hit = bit_hit(lvl, msk, sns);

endmodule

// File: rtl/fault_mon.sv
module fault_mon
    import fmon_pkg::*;
#(
    parameter int unsigned N_IN       = DEF_N_IN,
    parameter int unsigned RELOAD_CYC = DEF_RELOAD_CYC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] mon_in,
    input  logic            cfg_load,
    input  logic [N_IN-1:0] cfg_mask,
    input  logic [N_IN-1:0] cfg_sense,
    output logic            fault,
    output logic            busy
);

    logic [N_IN-1:0] act_mask, act_sense, hit;
    logic            busy_w;
    logic            fault_q;

    fmon_reload #(
        .N_IN       (N_IN),
        .RELOAD_CYC (RELOAD_CYC)
    ) reload_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_load  (cfg_load),
        .cfg_mask  (cfg_mask),
        .cfg_sense (cfg_sense),
        .act_mask  (act_mask),
        .act_sense (act_sense),
        .busy      (busy_w)
    );

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_det
        fmon_bit_det det_i (
            .lvl (mon_in[gi]),
            .msk (act_mask[gi]),
            .sns (act_sense[gi]),
            .hit (hit[gi])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
        end else if (cfg_load || busy_w) begin
            fault_q <= 1'b0;
        end else begin
            fault_q <= |hit;
        end
    end

    assign fault = fault_q;
    assign busy  = busy_w;

    // R6: flag held low after a load pulse and during reload
    a_r6_blank: assert property (@(posedge clk) disable iff (rst)
        (busy_w || cfg_load) |=> !fault);

    // R2: a fully masked bank never flags
    a_r2_all_masked: assert property (@(posedge clk) disable iff (rst)
        (&act_mask) |=> !fault);

    // R9: reset state
    a_r9_reset: assert property (@(posedge clk)
        rst |=> (!fault && !busy && (&act_mask) && (act_sense == '0)));

endmodule

// File: tb/fault_mon_tb_top.sv
module fault_mon_tb_top;

    localparam int RL = 6;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] mon_in;
    logic       cfg_load;
    logic [7:0] cfg_mask, cfg_sense;
    logic       fault, busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fault_mon #(.N_IN(8), .RELOAD_CYC(RL)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .mon_in    (mon_in),
        .cfg_load  (cfg_load),
        .cfg_mask  (cfg_mask),
        .cfg_sense (cfg_sense),
        .fault     (fault),
        .busy      (busy)
    );

    // {mask, sense, inputs, expected fault}
    localparam logic [24:0] VEC [0:9] = '{
        {8'h00, 8'h00, 8'h00, 1'b1},   // R3 low is fault
        {8'h00, 8'hFF, 8'h00, 1'b0},   // R3 high is fault, none high
        {8'h00, 8'hFF, 8'h01, 1'b1},   // R1 single input
        {8'hFE, 8'hFF, 8'hFE, 1'b0},   // R2 masked bits high ignored
        {8'hFE, 8'hFF, 8'h01, 1'b1},   // R2 only enabled bit counts
        {8'h7F, 8'h00, 8'h7F, 1'b1},   // R3 bit7 low
        {8'h7F, 8'h00, 8'h80, 1'b0},   // R3 bit7 high ok
        {8'hFF, 8'h00, 8'h00, 1'b0},   // R2 all masked
        {8'hA5, 8'h5A, 8'h5A, 1'b1},   // R1 mixed pattern
        {8'hA5, 8'h5A, 8'hA5, 1'b0}    // R1 mixed pattern clear
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Starts and ends just after a falling edge
    task automatic load_cfg(input logic [7:0] m, input logic [7:0] s);
        cfg_mask = m; cfg_sense = s; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        chk("R5", busy, 1'b1);
        chk("R6", fault, 1'b0);
        repeat (RL - 1) @(negedge clk);
        chk("R5", busy, 1'b1);
        @(negedge clk);
        chk("R5", busy, 1'b0);
    endtask

    initial begin
        rst = 1'b1; mon_in = '0; cfg_load = 1'b0; cfg_mask = '0; cfg_sense = '0;
        repeat (3) @(negedge clk);
        chk("R9", busy, 1'b0);
        chk("R9", fault, 1'b0);
        rst = 1'b0;
        mon_in = 8'h00;
        @(negedge clk);
        chk("R9", fault, 1'b0);      // everything masked after reset
        mon_in = 8'hFF;
        @(negedge clk);
        chk("R9", fault, 1'b0);

        // table walk
        for (int i = 0; i < 10; i++) begin
            load_cfg(VEC[i][24:17], VEC[i][16:9]);
            mon_in = VEC[i][8:1];
            @(negedge clk);
            chk("R1", fault, VEC[i][0]);
        end

        // R4: single-cycle input pulse gives single-cycle flag
        load_cfg(8'hFE, 8'hFF);
        mon_in = 8'h00;
        @(negedge clk); chk("R4", fault, 1'b0);
        mon_in = 8'h01;
        @(negedge clk); chk("R4", fault, 1'b1);
        mon_in = 8'h00;
        @(negedge clk); chk("R4", fault, 1'b0);

        // R8: reload restarted by a second load
        cfg_mask = 8'hFF; cfg_sense = 8'h00; cfg_load = 1'b1;
        @(negedge clk); cfg_load = 1'b0;
        repeat (3) @(negedge clk);
        cfg_mask = 8'hFE; cfg_sense = 8'hFF; cfg_load = 1'b1;
        @(negedge clk); cfg_load = 1'b0;
        repeat (RL - 1) @(negedge clk);
        chk("R8", busy, 1'b1);
        @(negedge clk);
        chk("R8", busy, 1'b0);
        mon_in = 8'h01;
        @(negedge clk); chk("R8", fault, 1'b1);

        // R6 / R7: blanking during reload; only the captured words apply
        load_cfg(8'h00, 8'h00);
        mon_in = 8'h00;
        @(negedge clk); chk("R6", fault, 1'b1);
        cfg_mask = 8'h00; cfg_sense = 8'h00; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0; cfg_mask = 8'hFF; cfg_sense = 8'hFF;
        for (int k = 0; k < RL; k++) begin
            chk("R6", fault, 1'b0);
            @(negedge clk);
        end
        chk("R5", busy, 1'b0);
        chk("R6", fault, 1'b0);
        @(negedge clk); chk("R7", fault, 1'b1);
        repeat (3) @(negedge clk);
        chk("R7", fault, 1'b1);      // bus change without load ignored

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule